// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of every line in a small direct-mapped write-back cache that shares a snooping bus with other caches. Each line is Modified, Exclusive, Shared or Invalid. Modified is the only dirty state. The controller serves one processor request at a time and watches the bus for reads and invalidates issued by other agents. It turns each situation into one of a fixed set of events: read hit, read miss shared, read miss exclusive, write hit, write miss, snooped read hit, snooped invalidate hit, and eviction of a conflicting line.

Each event maps onto at most three kinds of bus transaction: Push writes a dirty line back, Invalidate tells the other caches to drop their copies, and Read fetches a line. The bus port raises a request that holds its command and line address until a one-cycle grant. During the grant of a Read, the `bus_shared` input reports whether another cache also holds the line. A snoop is answered through `snp_hit` in the cycle it is presented. Snoops take priority over a waiting processor request. The data array and memory sit outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: no bus request is raised, the processor and snoop ports are ready, and every snoop reports no hit.
- R2: A read hit raises no bus request, leaves the line state unchanged, and pulses `req_done` with `req_hit`=1 in the cycle after the request is accepted.
- R3: A read miss issues a Read (`bus_cmd`=3) for the request's line address. The line becomes Shared if `bus_shared` is 1 during the grant and Exclusive otherwise. `req_done` pulses with `req_hit`=0 in the cycle after that grant.
- R4: A write hit on Modified or Exclusive completes without bus traffic and leaves the line Modified. A write hit on Shared first issues an Invalidate (`bus_cmd`=2) for the line and then leaves it Modified.
- R5: A write miss issues a Read. If `bus_shared` was 1 during that grant, an Invalidate for the same line follows. Either way the line ends Modified.
- R6: A snooped read (`snp_kind`=0) that hits a Modified line issues a Push (`bus_cmd`=1) of that line and leaves it Shared. A hit on Exclusive becomes Shared without traffic, and Shared stays Shared.
- R7: A snooped invalidate (`snp_kind`=1) that hits a valid line leaves it Invalid, and a Modified line is pushed first.
- R8: A miss on a set held by a different valid line evicts that line. A Modified victim is pushed at its own address before the Read. A clean victim is dropped without traffic.
- R9: A raised bus request keeps its command and address until granted. While a snoop is presented, `req_ready` is 0. Both ports are ready only when the controller is idle.
- R10: A snoop that misses reports `snp_hit`=0, raises no bus request and changes no line.
- R11: The line address is split into a set index in its low log2(NLINES) bits and a tag in the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Processor line address |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_done | output | 1 | One-cycle completion pulse |
| req_hit | output | 1 | Completed request hit a valid line |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_kind | input | 1 | 0 = read, 1 = invalidate |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_ready | output | 1 | Snoop accepted on this edge when valid |
| snp_hit | output | 1 | This cache holds the snooped line |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 1 Push, 2 Invalidate, 3 Read, 0 none |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_gnt | input | 1 | Grant; the transaction completes on this edge |
| bus_shared | input | 1 | Another cache holds the line, valid with a Read grant |

## Verification
A line left in the wrong state stays hidden until the next access to it. A line wrongly left Exclusive shows up when a later write hit lacks its Invalidate. A wrong Shared shows up as an extra Invalidate. A line that should be Modified but is not shows up as a missing Push on the next snoop or eviction of that line. For this reason the bench keeps its own per-line state and compares every bus command and address, cycle by cycle, on the accesses that follow. Timing errors appear at once, as a `req_done` pulse that arrives in the wrong cycle or a request that changes while it waits for a grant.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    BUS_NONE  = 2'd0,
    BUS_PUSH  = 2'd1,
    BUS_INVAL = 2'd2,
    BUS_READ  = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_SRD  = 2'd2,
    OP_SINV = 2'd3
  } probe_op_t;

  typedef enum logic [3:0] {
    EV_NONE  = 4'd0,
    EV_RH    = 4'd1,
    EV_RMS   = 4'd2,
    EV_RME   = 4'd3,
    EV_WH    = 4'd4,
    EV_WM    = 4'd5,
    EV_SHR   = 4'd6,
    EV_SHI   = 4'd7,
    EV_EVICT = 4'd8
  } mesi_ev_t;

  // state reached by a line after an event
  function automatic mesi_t mesi_next(mesi_t cur, mesi_ev_t ev);
    mesi_t nx;
    case (ev)
      EV_RMS:          nx = ST_S;
      EV_RME:          nx = ST_E;
      EV_WH, EV_WM:    nx = ST_M;
      EV_SHR:          nx = (cur == ST_I) ? ST_I : ST_S;
      EV_SHI, EV_EVICT: nx = ST_I;
      default:         nx = cur;
    endcase
    return nx;
  endfunction

  // a line in this state must be written back before it leaves
  function automatic logic mesi_dirty(mesi_t st);
    return st == ST_M;
  endfunction

  // write hit needs to tell the other caches first
  function automatic logic mesi_needs_upgrade(mesi_t st);
    return st == ST_S;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int TAGW   = 5,
  localparam int IDXW  = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] a_idx,
  output mesi_t           a_state,
  output logic [TAGW-1:0] a_tag,
  input  logic [IDXW-1:0] b_idx,
  output mesi_t           b_state,
  output logic [TAGW-1:0] b_tag,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [TAGW-1:0] wr_tag,
  input  mesi_t           wr_state
);

  logic [1:0]      st_q  [NLINES];
  logic [TAGW-1:0] tag_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_state;
      tag_q[wr_idx] <= wr_tag;
    end
  end

  assign a_state = mesi_t'(st_q[a_idx]);
  assign a_tag   = tag_q[a_idx];
  assign b_state = mesi_t'(st_q[b_idx]);
  assign b_tag   = tag_q[b_idx];

endmodule

// File: rtl/mesi_probe.sv
module mesi_probe
  import mesi_pkg::*;
#(
  parameter int TAGW = 5
) (
  input  mesi_t           line_state,
  input  logic [TAGW-1:0] line_tag,
  input  logic [TAGW-1:0] probe_tag,
  input  probe_op_t       op,
  input  logic            shared_in,
  output logic            hit,
  output logic            evict,
  output mesi_ev_t        ev
);

  logic valid, match, local_op;

  assign valid    = (line_state != ST_I);
  assign match    = (line_tag == probe_tag);
  assign local_op = (op == OP_RD) || (op == OP_WR);
  assign hit      = valid && match;
  assign evict    = valid && !match && local_op;

  always_comb begin
    case (op)
      OP_RD:   ev = hit ? EV_RH : (shared_in ? EV_RMS : EV_RME);
      OP_WR:   ev = hit ? EV_WH : EV_WM;
      OP_SRD:  ev = hit ? EV_SHR : EV_NONE;
      default: ev = hit ? EV_SHI : EV_NONE;
    endcase
  end

endmodule

// File: rtl/mesi_bus_seq.sv
module mesi_bus_seq
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int ADDR_W = 8,
  localparam int IDXW  = $clog2(NLINES),
  localparam int TAGW  = ADDR_W - IDXW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              req_done,
  output logic              req_hit,
  input  logic              snp_valid,
  input  logic              snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ready,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  output logic [ADDR_W-1:0] p_look,
  output logic              p_wr,
  output logic [ADDR_W-1:0] s_look,
  output logic              s_inv,
  input  logic              p_hit,
  input  logic              p_evict,
  input  mesi_ev_t          p_ev,
  input  mesi_t             p_state,
  input  logic [TAGW-1:0]   p_tag,
  input  logic              s_hit,
  input  mesi_ev_t          s_ev,
  input  mesi_t             s_state,
  output logic              wr_en,
  output logic [IDXW-1:0]   wr_idx,
  output logic [TAGW-1:0]   wr_tag,
  output mesi_t             wr_state
);

  typedef enum logic [2:0] {
    F_IDLE, F_VPUSH, F_FILL, F_UPGR, F_DONE, F_SPUSH
  } fsm_t;

  fsm_t              fsm_q, fsm_d;
  logic [ADDR_W-1:0] cur_addr_q, vic_addr_q, snp_addr_q;
  logic              cur_wr_q, hit_q, snp_inv_q;
  logic              idle, take_snp, take_req, gnt_now;

  assign idle     = (fsm_q == F_IDLE);
  assign take_snp = idle && snp_valid;
  assign take_req = idle && !snp_valid && req_valid;
  assign gnt_now  = bus_req && bus_gnt;

  assign req_ready = idle && !snp_valid;
  assign snp_ready = idle;
  assign req_done  = (fsm_q == F_DONE);
  assign req_hit   = hit_q;

  assign p_look = idle ? req_addr  : cur_addr_q;
  assign p_wr   = idle ? req_write : cur_wr_q;
  assign s_look = idle ? snp_addr  : snp_addr_q;
  assign s_inv  = idle ? snp_kind  : snp_inv_q;

  always_comb begin
    bus_req  = 1'b1;
    bus_cmd  = BUS_NONE;
    bus_addr = cur_addr_q;
    case (fsm_q)
      F_VPUSH: begin bus_cmd = BUS_PUSH;  bus_addr = vic_addr_q; end
      F_FILL:  bus_cmd = BUS_READ;
      F_UPGR:  bus_cmd = BUS_INVAL;
      F_SPUSH: begin bus_cmd = BUS_PUSH;  bus_addr = snp_addr_q; end
      default: begin bus_req = 1'b0; bus_addr = '0; end
    endcase
  end

  always_comb begin
    fsm_d    = fsm_q;
    wr_en    = 1'b0;
    wr_idx   = p_look[IDXW-1:0];
    wr_tag   = p_look[ADDR_W-1:IDXW];
    wr_state = p_state;
    case (fsm_q)
      F_IDLE: begin
        if (take_snp) begin
          if (s_hit && mesi_dirty(s_state)) begin
            fsm_d = F_SPUSH;
          end else if (s_hit) begin
            wr_en    = 1'b1;
            wr_idx   = s_look[IDXW-1:0];
            wr_tag   = s_look[ADDR_W-1:IDXW];
            wr_state = mesi_next(s_state, s_ev);
          end
        end else if (take_req) begin
          if (p_hit) begin
            if (req_write && mesi_needs_upgrade(p_state)) begin
              fsm_d = F_UPGR;
            end else begin
              wr_en    = 1'b1;
              wr_state = mesi_next(p_state, p_ev);
              fsm_d    = F_DONE;
            end
          end else if (p_evict && mesi_dirty(p_state)) begin
            fsm_d = F_VPUSH;
          end else begin
            wr_en    = p_evict;
            wr_tag   = p_tag;
            wr_state = mesi_next(p_state, EV_EVICT);
            fsm_d    = F_FILL;
          end
        end
      end
      F_VPUSH: if (bus_gnt) begin
        wr_en    = 1'b1;
        wr_tag   = p_tag;
        wr_state = mesi_next(p_state, EV_EVICT);
        fsm_d    = F_FILL;
      end
      F_FILL: if (bus_gnt) begin
        wr_en = 1'b1;
        if (cur_wr_q) begin
          wr_state = bus_shared ? ST_S : ST_M;
          fsm_d    = bus_shared ? F_UPGR : F_DONE;
        end else begin
          wr_state = mesi_next(ST_I, p_ev);
          fsm_d    = F_DONE;
        end
      end
      F_UPGR: if (bus_gnt) begin
        wr_en    = 1'b1;
        wr_state = mesi_next(p_state, EV_WH);
        fsm_d    = F_DONE;
      end
      F_DONE: fsm_d = F_IDLE;
      F_SPUSH: if (bus_gnt) begin
        wr_en    = 1'b1;
        wr_idx   = s_look[IDXW-1:0];
        wr_tag   = s_look[ADDR_W-1:IDXW];
        wr_state = mesi_next(ST_M, s_ev);
        fsm_d    = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q      <= F_IDLE;
      cur_addr_q <= '0;
      vic_addr_q <= '0;
      snp_addr_q <= '0;
      cur_wr_q   <= 1'b0;
      hit_q      <= 1'b0;
      snp_inv_q  <= 1'b0;
    end else begin
      fsm_q <= fsm_d;
      if (take_snp) begin
        snp_addr_q <= snp_addr;
        snp_inv_q  <= snp_kind;
      end
      if (take_req) begin
        cur_addr_q <= req_addr;
        cur_wr_q   <= req_write;
        hit_q      <= p_hit;
        vic_addr_q <= {p_tag, req_addr[IDXW-1:0]};
      end
    end
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R4
  silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && p_hit && p_state == ST_E |=> !bus_req && req_done);

  // R7
  dirty_snoop_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_ready && s_hit && s_state == ST_M |=> bus_req && bus_cmd == BUS_PUSH);

  // R8
  victim_push_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !p_hit && p_evict && p_state == ST_M |=> bus_req && bus_cmd == BUS_PUSH);

  // R3
  fill_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_now && bus_cmd == BUS_READ && !cur_wr_q && !bus_shared |=> p_state == ST_E);

  // R5
  write_miss_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_now && bus_cmd == BUS_READ && cur_wr_q && bus_shared |=> bus_req && bus_cmd == BUS_INVAL);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              req_done,
  output logic              req_hit,
  input  logic              snp_valid,
  input  logic              snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ready,
  output logic              snp_hit,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared
);

  localparam int IDXW = $clog2(NLINES);
  localparam int TAGW = ADDR_W - IDXW;

  logic [ADDR_W-1:0] p_look, s_look;
  logic              p_wr, s_inv;
  mesi_t             p_state, s_state, wr_state;
  logic [TAGW-1:0]   p_tag, s_tag, wr_tag;
  logic              p_hit, p_evict, s_hit, s_evict_unused;
  mesi_ev_t          p_ev, s_ev;
  logic              wr_en;
  logic [IDXW-1:0]   wr_idx;
  bus_cmd_t          cmd_w;
  probe_op_t         p_op, s_op;

  assign p_op    = p_wr  ? OP_WR   : OP_RD;
  assign s_op    = s_inv ? OP_SINV : OP_SRD;
  assign bus_cmd = cmd_w;
  assign snp_hit = snp_valid && snp_ready && s_hit;

  mesi_line_store #(.NLINES(NLINES), .TAGW(TAGW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(p_look[IDXW-1:0]), .a_state(p_state), .a_tag(p_tag),
    .b_idx(s_look[IDXW-1:0]), .b_state(s_state), .b_tag(s_tag),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state)
  );

  mesi_probe #(.TAGW(TAGW)) u_probe_local (
    .line_state(p_state), .line_tag(p_tag), .probe_tag(p_look[ADDR_W-1:IDXW]),
    .op(p_op), .shared_in(bus_shared),
    .hit(p_hit), .evict(p_evict), .ev(p_ev)
  );

  mesi_probe #(.TAGW(TAGW)) u_probe_snoop (
    .line_state(s_state), .line_tag(s_tag), .probe_tag(s_look[ADDR_W-1:IDXW]),
    .op(s_op), .shared_in(1'b0),
    .hit(s_hit), .evict(s_evict_unused), .ev(s_ev)
  );

  mesi_bus_seq #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .req_done(req_done), .req_hit(req_hit),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .snp_ready(snp_ready),
    .bus_req(bus_req), .bus_cmd(cmd_w), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared),
    .p_look(p_look), .p_wr(p_wr), .s_look(s_look), .s_inv(s_inv),
    .p_hit(p_hit), .p_evict(p_evict), .p_ev(p_ev), .p_state(p_state), .p_tag(p_tag),
    .s_hit(s_hit), .s_ev(s_ev), .s_state(s_state),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state)
  );

  // R10
  snoop_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_ready && !s_hit |=> !bus_req);

  // R6
  clean_snoop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_ready && !snp_kind && s_hit && s_state != ST_M |=> !bus_req);

endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;

  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, req_done, req_hit;
  logic snp_valid = 0, snp_kind = 0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_ready, snp_hit;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 0, bus_shared = 0;

  int checks = 0;
  int errors = 0;

  // reference line model: 0 I, 1 S, 2 E, 3 M
  int         m_st  [8];
  logic [4:0] m_tag [8];

  int         exp_cmd  [3];
  logic [7:0] exp_addr [3];
  string      exp_req  [3];
  int         n_exp;

  always #5 clk = ~clk;

  mesi_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .req_done(req_done), .req_hit(req_hit),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .snp_ready(snp_ready), .snp_hit(snp_hit),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared)
  );

  function automatic int idx_of(logic [7:0] a);
    return int'(a[2:0]);
  endfunction

  function automatic logic [4:0] tag_of(logic [7:0] a);
    return a[7:3];
  endfunction

  function automatic logic m_hit(logic [7:0] a);
    return m_st[idx_of(a)] != 0 && m_tag[idx_of(a)] == tag_of(a);
  endfunction

  task automatic chk(input logic ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic add_exp(input int c, input logic [7:0] a, input string rq);
    exp_cmd[n_exp]  = c;
    exp_addr[n_exp] = a;
    exp_req[n_exp]  = rq;
    n_exp++;
  endtask

  // wait on bus requests, granting after dly cycles each, until the end
  task automatic serve_bus(input int dly, input logic sh, input logic want_done,
                           input logic exp_hit, input string rq);
    int cyc = 0;
    int k = 0;
    int cnt = dly;
    logic fin = 0;
    while (!fin) begin
      cyc++;
      if (want_done && req_done) begin
        chk(req_hit == exp_hit, rq, "req_hit", req_hit, exp_hit);
        chk(cyc == n_exp * (dly + 1) + 1, rq, "done cycle", cyc, n_exp * (dly + 1) + 1);
        chk(k == n_exp, rq, "bus ops", k, n_exp);
        fin = 1;
      end else if (bus_req) begin
        if (k >= n_exp) begin
          chk(0, rq, "unexpected bus cmd", bus_cmd, 0);
          fin = 1;
        end else begin
          chk(bus_cmd == exp_cmd[k][1:0], exp_req[k], "bus_cmd", bus_cmd, exp_cmd[k]);
          chk(bus_addr == exp_addr[k], exp_req[k], "bus_addr", bus_addr, exp_addr[k]);
          if (cnt > 0) cnt--;
          else begin
            bus_gnt = 1;
            bus_shared = sh;
            k++;
            cnt = dly;
          end
        end
      end else if (!want_done) begin
        chk(k == n_exp, rq, "snoop bus ops", k, n_exp);
        fin = 1;
      end
      if (cyc > 60) begin
        chk(0, rq, "stuck", cyc, 0);
        fin = 1;
      end
      @(negedge clk);
      bus_gnt = 0;
    end
  endtask

  task automatic snoop_op(input logic kind, input logic [7:0] a, input int dly);
    int i = idx_of(a);
    logic h = m_hit(a);
    string rq = !h ? "R10" : (kind ? "R7" : "R6");
    n_exp = 0;
    if (h && m_st[i] == 3) add_exp(1, a, rq);
    @(negedge clk);
    snp_valid = 1; snp_kind = kind; snp_addr = a;
    #1;
    chk(snp_ready == 1, "R9", "snp_ready", snp_ready, 1);
    chk(snp_hit == h, rq, "snp_hit", snp_hit, h);
    if (h) m_st[i] = kind ? 0 : 1;
    @(negedge clk);
    snp_valid = 0;
    serve_bus(dly, 0, 0, 0, rq);
  endtask

  task automatic proc_op(input logic w, input logic [7:0] a, input logic sh,
                         input int dly, input logic with_snp, input logic sk,
                         input logic [7:0] sa);
    int i;
    logic h;
    string rq;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a;
    if (with_snp) begin
      snp_valid = 1; snp_kind = sk; snp_addr = sa;
      #1;
      chk(req_ready == 0, "R9", "req_ready under snoop", req_ready, 0);
      chk(snp_hit == m_hit(sa), "R10", "snp_hit with pending request", snp_hit, m_hit(sa));
      if (m_hit(sa)) m_st[idx_of(sa)] = sk ? 0 : 1;
      @(negedge clk);
      snp_valid = 0;
    end
    #1;
    chk(req_ready == 1, "R9", "req_ready idle", req_ready, 1);
    i = idx_of(a);
    h = m_hit(a);
    n_exp = 0;
    if (!h && m_st[i] == 3) add_exp(1, {m_tag[i], a[2:0]}, "R8");
    if (!h) add_exp(3, a, w ? "R5" : "R3");
    if (w && ((h && m_st[i] == 1) || (!h && sh))) add_exp(2, a, h ? "R4" : "R5");
    rq = h ? (w ? "R4" : "R2") : (w ? "R5" : "R3");
    m_tag[i] = tag_of(a);
    m_st[i]  = w ? 3 : (h ? m_st[i] : (sh ? 1 : 2));
    @(negedge clk);
    req_valid = 0;
    serve_bus(dly, sh, 1, h, rq);
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, sa;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle after reset, nothing cached
    chk(bus_req == 0, "R1", "bus_req", bus_req, 0);
    chk(req_done == 0, "R1", "req_done", req_done, 0);
    chk(snp_ready == 1, "R1", "snp_ready", snp_ready, 1);
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    snoop_op(0, 8'h05, 0);
    snoop_op(1, 8'h01, 0);

    // R11: address 0x01 is set 1, tag 0
    proc_op(0, 8'h01, 0, 0, 0, 0, 0);   // R3 read miss -> E
    proc_op(0, 8'h01, 0, 0, 0, 0, 0);   // R2 read hit
    proc_op(1, 8'h01, 0, 0, 0, 0, 0);   // R4 E -> M silent
    snoop_op(0, 8'h01, 0);              // R6 push, -> S
    proc_op(1, 8'h01, 0, 0, 0, 0, 0);   // R4 S -> invalidate -> M
    snoop_op(1, 8'h01, 1);              // R7 push, -> I
    snoop_op(0, 8'h01, 0);              // R10 miss now
    proc_op(0, 8'h01, 1, 0, 0, 0, 0);   // R3 shared -> S
    snoop_op(0, 8'h01, 0);              // R6 S stays S
    proc_op(1, 8'h02, 1, 0, 0, 0, 0);   // R5 read then invalidate
    proc_op(0, 8'h0A, 0, 0, 0, 0, 0);   // R8 dirty victim pushed
    proc_op(0, 8'h12, 0, 0, 0, 0, 0);   // R8 clean victim dropped
    proc_op(1, 8'h03, 0, 0, 0, 0, 0);   // R5 no sharer -> M directly
    proc_op(0, 8'h03, 0, 0, 1, 1, 8'h01); // R9 snoop wins
    proc_op(1, 8'h04, 1, 2, 0, 0, 0);   // R9 held request during wait
    snoop_op(1, 8'h04, 2);              // R7 push with delayed grant

    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 9);
      a  = {3'b000, 2'($urandom_range(0, 2)), 3'($urandom_range(0, 3))};
      sa = {3'b000, 2'($urandom_range(0, 2)), 3'($urandom_range(0, 3))};
      if (r < 3) begin
        snoop_op(1'($urandom_range(0, 1)), a, $urandom_range(0, 2));
      end else begin
        logic ws = (r == 9) && (m_st[idx_of(sa)] != 3 || !m_hit(sa));
        proc_op(1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)),
                $urandom_range(0, 2), ws, 1'($urandom_range(0, 1)), sa);
      end
    end

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule